// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit is the shifter slice of a 32-bit integer execute stage. It receives the six-bit function code of a register-format instruction, both source operands, the five-bit immediate shift amount and the two instruction bits that pick rotation. From these it produces the value to be written to the destination register. The amount comes either from the immediate field or from the low bits of the second source register.

Logical right shift and right rotate share one function code. They are told apart only by a select bit, and that bit sits at a different instruction position for the immediate-amount form than for the register-amount form. Any function code outside the six shift codes raises an illegal-operation flag and forces the result to zero. The result and the flag are registered by default, so they appear one clock after the operands. A parameter removes that register for a purely combinational slice.

Top module: `shift_rotate_unit`

## Requirements
- R1: Function code 0x00 shifts rt left by `sa_i`, filling the vacated low bits with zeros.
- R2: Function code 0x02 with `rot_fix_i` = 0 shifts rt right by `sa_i`, filling the vacated high bits with zeros.
- R3: Function code 0x02 with `rot_fix_i` = 1 rotates rt right by `sa_i`. Each bit leaving bit 0 re-enters at bit 31, so the result equals (rt >> n) | (rt << (32 - n)) for n > 0.
- R4: Function code 0x03 shifts rt right by `sa_i` and copies bit 31 of rt into every vacated bit.
- R5: Function codes 0x04, 0x06 and 0x07 perform the left shift, the right shift or rotate, and the sign-filling right shift with the amount taken from rs[4:0]. Bits rs[31:5] and `sa_i` have no effect on these codes. For codes 0x00, 0x02 and 0x03, rs has no effect.
- R6: Function code 0x06 rotates when `rot_var_i` = 1 and shifts logically when it is 0. `rot_var_i` has no effect on code 0x02, and `rot_fix_i` has no effect on code 0x06.
- R7: An amount of zero returns rt unchanged for every supported code.
- R8: Every function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07 (for example 0x01 and 0x05) drives `illegal_o` to 1 and `result_o` to zero. For supported codes, `illegal_o` is 0.
- R9: With the default `REG_OUT` = 1, the result and the flag appear on the first rising edge after the operands are presented. While `rst` is high, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_i | input | 6 | Function code of the instruction |
| rt_i | input | 32 | Operand that is shifted or rotated |
| rs_i | input | 32 | Operand whose low five bits give the variable amount |
| sa_i | input | 5 | Immediate shift amount |
| rot_fix_i | input | 1 | Rotate select for the immediate-amount form (instruction bit 21) |
| rot_var_i | input | 1 | Rotate select for the register-amount form (instruction bit 6) |
| result_o | output | 32 | Value for the destination register |
| illegal_o | output | 1 | Function code is not a shift or rotate |

## Verification
The assertions assume that every input is driven to a known value on each clock edge after reset. They also assume the datapath width is a power of two, so that every amount fits the barrel stages. The bench changes inputs only at falling edges and keeps them at defined values throughout. It sweeps every amount from 0 to 31 for the supported codes, for several illegal codes, and for all four combinations of the two select bits. For each code it randomizes whichever operand fields that code must ignore, so that the selection paths are exercised while the inputs stay within those assumptions.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [1:0] {
        OP_SLL = 2'd0,
        OP_SRL = 2'd1,
        OP_SRA = 2'd2,
        OP_ROR = 2'd3
    } shr_op_e;

    typedef struct packed {
        shr_op_e op;
        logic    var_amt;
        logic    illegal;
    } shr_ctrl_t;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_SLLV = 6'h04;
    localparam logic [5:0] FN_SRLV = 6'h06;
    localparam logic [5:0] FN_SRAV = 6'h07;

    function automatic shr_op_e right_kind(input logic rot);
        return rot ? OP_ROR : OP_SRL;
    endfunction

endpackage

// File: rtl/shr_decode.sv
module shr_decode
    import shr_pkg::*;
(
    input  logic [5:0] func_i,
    input  logic       rot_fix_i,
    input  logic       rot_var_i,
    output shr_ctrl_t  ctrl_o
);
    always_comb begin
        ctrl_o = '{op: OP_SLL, var_amt: 1'b0, illegal: 1'b0};
        case (func_i)
            FN_SLL:  ctrl_o.op = OP_SLL;
            FN_SRL:  ctrl_o.op = right_kind(rot_fix_i);
            FN_SRA:  ctrl_o.op = OP_SRA;
            FN_SLLV: begin ctrl_o.op = OP_SLL; ctrl_o.var_amt = 1'b1; end
            FN_SRLV: begin ctrl_o.op = right_kind(rot_var_i); ctrl_o.var_amt = 1'b1; end
            FN_SRAV: begin ctrl_o.op = OP_SRA; ctrl_o.var_amt = 1'b1; end
            default: ctrl_o.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/shr_barrel.sv
module shr_barrel
    import shr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  shr_op_e           op_i,
    output logic [DATA_W-1:0] data_o
);
    // Left shifts reuse the right-shift stages on a bit-reversed word.
    logic              go_left;
    logic              wrap;
    logic              fill;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] stg [0:AMT_W];

    assign go_left = (op_i == OP_SLL);
    assign wrap    = (op_i == OP_ROR);
    assign fill    = (op_i == OP_SRA) & data_i[DATA_W-1];

    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign rev_in[b]  = data_i[DATA_W-1-b];
        assign rev_out[b] = stg[AMT_W][DATA_W-1-b];
    end

    assign stg[0] = go_left ? rev_in : data_i;

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        logic [STEP-1:0]   top_bits;
        logic [DATA_W-1:0] moved;
        assign top_bits   = wrap ? stg[i][STEP-1:0] : {STEP{fill}};
        assign moved      = {top_bits, stg[i][DATA_W-1:STEP]};
        assign stg[i+1]   = amt_i[i] ? moved : stg[i];
    end

    assign data_o = go_left ? rev_out : stg[AMT_W];
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import shr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int AMT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        func_i,
    input  logic [DATA_W-1:0] rt_i,
    input  logic [DATA_W-1:0] rs_i,
    input  logic [AMT_W-1:0]  sa_i,
    input  logic              rot_fix_i,
    input  logic              rot_var_i,
    output logic [DATA_W-1:0] result_o,
    output logic              illegal_o
);
    shr_ctrl_t         ctrl;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] res_d;
    logic              unused_rs_hi;

    assign unused_rs_hi = ^rs_i[DATA_W-1:AMT_W];

    shr_decode u_dec (
        .func_i    (func_i),
        .rot_fix_i (rot_fix_i),
        .rot_var_i (rot_var_i),
        .ctrl_o    (ctrl)
    );

    assign amt = ctrl.var_amt ? rs_i[AMT_W-1:0] : sa_i;

    shr_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .data_i (rt_i),
        .amt_i  (amt),
        .op_i   (ctrl.op),
        .data_o (core_out)
    );

    assign res_d = ctrl.illegal ? '0 : core_out;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                result_o  <= '0;
                illegal_o <= 1'b0;
            end else begin
                result_o  <= res_d;
                illegal_o <= ctrl.illegal;
            end
        end
    end else begin : g_comb
        assign result_o  = res_d;
        assign illegal_o = ctrl.illegal;
    end

    // R7
    zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.illegal && amt == '0) |-> (core_out == rt_i));

    // R3
    rotate_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.illegal && ctrl.op == OP_ROR) |-> ($countones(core_out) == $countones(rt_i)));

    // R4
    sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.illegal && ctrl.op == OP_SRA && rt_i[DATA_W-1]) |-> core_out[DATA_W-1]);

    // R2
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.illegal && ctrl.op == OP_SRL && amt != '0) |-> !core_out[DATA_W-1]);

    // R1
    left_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.illegal && ctrl.op == OP_SLL && amt != '0) |-> !core_out[0]);

    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (result_o == '0));
endmodule

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  func_i = '0;
    logic [31:0] rt_i = '0;
    logic [31:0] rs_i = '0;
    logic [4:0]  sa_i = '0;
    logic        rot_fix_i = 1'b0;
    logic        rot_var_i = 1'b0;
    logic [31:0] result_o;
    logic        illegal_o;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    shift_rotate_unit i_shift_rotate_unit (
        .clk       (clk),
        .rst       (rst),
        .func_i    (func_i),
        .rt_i      (rt_i),
        .rs_i      (rs_i),
        .sa_i      (sa_i),
        .rot_fix_i (rot_fix_i),
        .rot_var_i (rot_var_i),
        .result_o  (result_o),
        .illegal_o (illegal_o)
    );

    function automatic logic [32:0] model(input logic [5:0] fn, input logic [31:0] rt,
                                          input logic [31:0] rs, input logic [4:0] sa,
                                          input logic sf, input logic sv);
        logic [4:0]  n;
        logic [63:0] dbl;
        n   = fn[2] ? rs[4:0] : sa;
        dbl = {rt, rt} >> n;
        case (fn)
            6'h00, 6'h04: return {1'b0, rt << n};
            6'h02:        return {1'b0, sf ? dbl[31:0] : rt >> n};
            6'h06:        return {1'b0, sv ? dbl[31:0] : rt >> n};
            6'h03, 6'h07: return {1'b0, 32'($signed(rt) >>> n)};
            default:      return {1'b1, 32'h0};
        endcase
    endfunction

    function automatic string tag(input logic [5:0] fn, input logic [4:0] n,
                                  input logic sf, input logic sv);
        if (!(fn inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07})) return "R8";
        if (n == 0) return "R7";
        case (fn)
            6'h00: return "R1";
            6'h02: return sf ? "R3" : "R2";
            6'h03: return "R4";
            6'h06: return sv ? "R6" : "R5";
            default: return "R5";
        endcase
    endfunction

    task automatic compare(input string req, input logic [32:0] exp);
        checks++;
        if ({illegal_o, result_o} !== exp) begin
            failures++;
            $display("FAIL %s: illegal/result actual=%0b/%08h expected=%0b/%08h",
                     req, illegal_o, result_o, exp[32], exp[31:0]);
        end
    endtask

    initial begin
        logic [5:0]  codes [11] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05,
                                    6'h06, 6'h07, 6'h08, 6'h22, 6'h3F};
        logic [31:0] pats  [4]  = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'hA5C3_0F96};
        // R9: reset state
        func_i = 6'h01; rt_i = 32'hFFFF_FFFF; sa_i = 5'd3;
        repeat (3) @(negedge clk);
        compare("R9", 33'h0);
        @(negedge clk);
        rst = 1'b0;
        foreach (codes[c]) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int n = 0; n < 32; n++) begin
                    for (int k = 0; k < 2; k++) begin
                        logic [32:0] exp;
                        func_i    = codes[c];
                        rot_fix_i = sel[0];
                        rot_var_i = sel[1];
                        rt_i      = k == 0 ? pats[n % 4] : $urandom;
                        if (codes[c][2]) begin
                            rs_i = {$urandom} & 32'hFFFF_FFE0 | 32'(n);
                            sa_i = 5'($urandom);
                        end else begin
                            rs_i = $urandom;
                            sa_i = 5'(n);
                        end
                        exp = model(func_i, rt_i, rs_i, sa_i, rot_fix_i, rot_var_i);
                        @(negedge clk);
                        // R9: value present one edge after the operands
                        compare(tag(func_i, 5'(n), rot_fix_i, rot_var_i), exp);
                    end
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule